// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that works through a chain of transfer descriptors kept in memory. Software first writes the byte address of the first descriptor. It then sets the start bit. The channel fetches the descriptor, moves the bytes it describes one beat at a time, and follows the descriptor's link word to the next one. It stops when the link word holds a reserved end marker. A chain whose last link points back to an earlier descriptor runs until software stops it.

A descriptor is six consecutive 32-bit words, in this order: configuration, source address, destination address, byte length, parameter, link. Descriptor fetches and data beats share one memory port. Read data on that port returns one cycle after the request. Each side of a transfer is either linear, where the address steps by the beat size, or fixed (IO), where the address stays put. A fixed side may be paced by one of 32 peripheral request lines. Progress events are pulsed on three outputs, and the working registers can be read back at any time.

Top module: `lli_dma_channel`

## Requirements
- R1: After reset the channel is idle, all eight register words read 0, and no memory access or event pulse occurs.
- R2: Writing 1 to bit 0 of word 0 while idle starts a fetch of six words from the address in word 2. The words are taken in the order configuration, source, destination, length, parameter, link.
- R3: The beat size comes from configuration bits 10:9, where code 0 means 1 byte, code 1 means 2 bytes and code 2 means 4 bytes. Bytes are taken from the source lane given by the address low bits and written to the destination lane with byte enables. A side whose mode bit is 0 (bit 5 for source, bit 21 for destination) steps its address by the beat size. A side whose mode bit is 1 keeps its address fixed.
- R4: A link word of 0xFFFFF800 ends the chain. The queue-done pulse comes in the same cycle as the last package-done pulse, and bit 0 of word 0 then reads 0.
- R5: Any other link word is fetched next. Package-done pulses once for every descriptor that completes.
- R6: A link that points back to an earlier descriptor repeats the chain without end. It pulses package-done each time and never pulses queue-done.
- R7: While bit 1 of word 1 is set, the channel issues no memory read and its registers hold. Clearing the bit resumes the transfer where it stopped.
- R8: Writing 0 to bit 0 of word 0 returns the channel to idle in the next cycle. After that it makes no further memory access and gives no event.
- R9: A fixed side whose request number is not 1 waits before each burst until its request line is high. The request number is configuration bits 4:0 for the source and bits 20:16 for the destination. Request number 1 is memory and counts as always ready. Source burst code 2 (bits 8:7) means 8 beats; any other code means 1 beat.
- R10: Word 2 reads the link pointer, and words 3 to 7 read the live configuration, source, destination, remaining byte count and parameter.
- R11: Half-done pulses exactly once per descriptor, after the first beat that leaves at most half of the length remaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| drq | input | 32 | Peripheral request lines |
| half_done | output | 1 | Half of descriptor moved |
| pkg_done | output | 1 | Descriptor completed |
| queue_done | output | 1 | Chain end reached |

## Verification
Package-done and queue-done fall in the same cycle when the last descriptor of a chain finishes. Half-done can share that cycle too, when a descriptor moves in a single beat. The bench runs two-descriptor chains and single-beat copies. It counts queue pulses seen without a package pulse, which must stay at zero, and it checks that exactly one package pulse is not joined by a queue pulse. A looping chain is used to confirm that queue-done never appears on its own.

// File: rtl/lli_dma_channel.sv
module lli_dma_channel #(
  parameter logic [31:0] END_MARK   = 32'hFFFF_F800,
  parameter int          BURST_LONG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] drq,
  output logic        half_done,
  output logic        pkg_done,
  output logic        queue_done
);
  localparam int BW = $clog2(BURST_LONG + 1);

  typedef enum logic [2:0] {S_IDLE, S_FREQ, S_FDAT, S_GATE, S_RD, S_WR} state_t;

  state_t      state_q;
  logic [31:0] ptr_q, cfg_q, src_q, dst_q, cnt_q, len_q, para_q;
  logic [2:0]  idx_q;
  logic [BW-1:0] beat_q;
  logic        pause_q, half_q;
  logic        busy, fetching;

  logic [31:0] bytes, cnt_new;
  logic [3:0]  be_base;
  logic        src_ok, dst_ok, last_beat;
  logic [BW-1:0] burst_len;

  assign busy     = state_q != S_IDLE;
  assign fetching = state_q == S_FREQ;

  always_comb begin
    case (cfg_q[10:9])
      2'd0:    begin bytes = 32'd1; be_base = 4'b0001; end
      2'd1:    begin bytes = 32'd2; be_base = 4'b0011; end
      default: begin bytes = 32'd4; be_base = 4'b1111; end
    endcase
  end

  assign cnt_new   = (cnt_q > bytes) ? cnt_q - bytes : 32'd0;
  assign last_beat = cnt_new == 32'd0;
  assign burst_len = (cfg_q[8:7] == 2'd2) ? BW'(BURST_LONG) : BW'(1);
  assign src_ok    = !cfg_q[5]  || cfg_q[4:0]   == 5'd1 || drq[cfg_q[4:0]];
  assign dst_ok    = !cfg_q[21] || cfg_q[20:16] == 5'd1 || drq[cfg_q[20:16]];

  assign mem_rd    = (state_q == S_FREQ || state_q == S_RD) && !pause_q;
  assign mem_wr    = state_q == S_WR;
  assign mem_addr  = fetching ? ptr_q + {27'd0, idx_q, 2'b00}
                   : (state_q == S_RD) ? {src_q[31:2], 2'b00} : {dst_q[31:2], 2'b00};
  assign mem_wdata = (mem_rdata >> {src_q[1:0], 3'b000}) << {dst_q[1:0], 3'b000};
  assign mem_be    = be_base << dst_q[1:0];

  always_comb begin
    case (reg_word)
      3'd0:    reg_rdata = {31'd0, busy};
      3'd1:    reg_rdata = {30'd0, pause_q, 1'b0};
      3'd2:    reg_rdata = ptr_q;
      3'd3:    reg_rdata = cfg_q;
      3'd4:    reg_rdata = src_q;
      3'd5:    reg_rdata = dst_q;
      3'd6:    reg_rdata = cnt_q;
      default: reg_rdata = para_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      {ptr_q, cfg_q, src_q, dst_q, cnt_q, len_q, para_q} <= '0;
      idx_q <= '0; beat_q <= '0; pause_q <= 1'b0; half_q <= 1'b0;
      half_done <= 1'b0; pkg_done <= 1'b0; queue_done <= 1'b0;
    end else begin
      half_done <= 1'b0; pkg_done <= 1'b0; queue_done <= 1'b0;
      case (state_q)
        S_FREQ: if (!pause_q) state_q <= S_FDAT;
        S_FDAT: begin
          case (idx_q)
            3'd0: cfg_q <= mem_rdata;
            3'd1: src_q <= mem_rdata;
            3'd2: dst_q <= mem_rdata;
            3'd3: begin cnt_q <= mem_rdata; len_q <= mem_rdata; end
            3'd4: para_q <= mem_rdata;
            default: ptr_q <= mem_rdata;
          endcase
          if (idx_q == 3'd5) begin idx_q <= '0; state_q <= S_GATE; end
          else begin idx_q <= idx_q + 3'd1; state_q <= S_FREQ; end
        end
        S_GATE: begin
          if (cnt_q == 32'd0) begin
            pkg_done <= 1'b1; half_q <= 1'b0;
            if (ptr_q == END_MARK) begin queue_done <= 1'b1; state_q <= S_IDLE; end
            else state_q <= S_FREQ;
          end else if (!pause_q && src_ok && dst_ok) begin
            beat_q <= burst_len; state_q <= S_RD;
          end
        end
        S_RD: if (!pause_q) state_q <= S_WR;
        S_WR: begin
          cnt_q <= cnt_new;
          if (!cfg_q[5])  src_q <= src_q + bytes;
          if (!cfg_q[21]) dst_q <= dst_q + bytes;
          if (!half_q && {cnt_new, 1'b0} <= {1'b0, len_q}) begin
            half_done <= 1'b1; half_q <= 1'b1;
          end
          if (last_beat) begin
            pkg_done <= 1'b1; half_q <= 1'b0;
            if (ptr_q == END_MARK) begin queue_done <= 1'b1; state_q <= S_IDLE; end
            else state_q <= S_FREQ;
          end else if (beat_q == BW'(1)) state_q <= S_GATE;
          else begin beat_q <= beat_q - BW'(1); state_q <= S_RD; end
        end
        default: ;
      endcase
      if (reg_we) begin
        case (reg_word)
          3'd0: begin
            if (!reg_wdata[0]) begin
              state_q <= S_IDLE;
              half_done <= 1'b0; pkg_done <= 1'b0; queue_done <= 1'b0;
            end else if (!busy) begin
              state_q <= S_FREQ; idx_q <= '0; half_q <= 1'b0;
            end
          end
          3'd1: pause_q <= reg_wdata[1];
          3'd2: if (!busy) ptr_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lli_dma_channel_chk.sv
module lli_dma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_word,
  input logic [31:0] reg_wdata,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        half_done,
  input logic        pkg_done,
  input logic        queue_done,
  input logic        busy,
  input logic        paused
);
  a_r4_queue_with_pkg: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |-> pkg_done);
  a_r7_pause_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_rd);
  a_r8_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_word == 3'd0 && !reg_wdata[0]) |=> !(mem_rd || mem_wr));
  a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr));
  a_r11_half_single: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> !half_done);
endmodule

bind lli_dma_channel lli_dma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
  .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .half_done(half_done), .pkg_done(pkg_done), .queue_done(queue_done),
  .busy(busy), .paused(pause_q)
);

// File: tb/lli_dma_channel_tb.sv
module lli_dma_channel_tb;
  localparam logic [31:0] ENDM = 32'hFFFF_F800;
  localparam logic [191:0] VEC [0:4] = '{
    {32'h0401_0401, 32'h010, 32'h200, 32'd8, 32'h204, 32'h1716_1514},
    {32'h0001_0001, 32'h021, 32'h242, 32'd2, 32'h240, 32'h2221_0000},
    {32'h0201_0301, 32'h030, 32'h280, 32'd4, 32'h280, 32'h3332_3130},
    {32'h0401_0421, 32'h040, 32'h2C0, 32'd8, 32'h2C4, 32'h4342_4140},
    {32'h0421_0401, 32'h050, 32'h300, 32'd8, 32'h300, 32'h5756_5554}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_word = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [31:0] drq = '0;
  logic half_done, pkg_done, queue_done;
  logic [31:0] mem [0:255];
  int checks = 0, errors = 0;
  int pkg_n = 0, q_n = 0, half_n = 0, acc_n = 0, q_alone = 0, pkg_alone = 0;

  always #10 clk = ~clk;

  lli_dma_channel u_dut (.*);

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(negedge clk) begin
    if (pkg_done) pkg_n++;
    if (queue_done) q_n++;
    if (half_done) half_n++;
    if (mem_rd || mem_wr) acc_n++;
    if (queue_done && !pkg_done) q_alone++;
    if (pkg_done && !queue_done) pkg_alone++;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); reg_word = w; #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input logic [31:0] c, s, d, l, n);
    mem[base/4]   = c; mem[base/4+1] = s; mem[base/4+2] = d;
    mem[base/4+3] = l; mem[base/4+4] = 32'd8; mem[base/4+5] = n;
  endtask

  task automatic clear_state();
    for (int i = 128; i < 256; i++) mem[i] = '0;
    pkg_n = 0; q_n = 0; half_n = 0; acc_n = 0; q_alone = 0; pkg_alone = 0;
  endtask

  task automatic wait_queue(input string tag);
    int t = 0;
    while (q_n == 0 && t < 3000) begin @(negedge clk); t++; end
    checks++;
    if (q_n == 0) begin errors++; $display("FAIL %s: actual no end expected end", tag); end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c1;
    logic [191:0] e;
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    for (int i = 64; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 8; w++) begin rd(3'(w), v); chk("R1 reset register", v, 0); end
    repeat (5) @(negedge clk);
    chk("R1 no access or event", acc_n + pkg_n + half_n, 0);

    for (int k = 0; k < 5; k++) begin
      e = VEC[k];
      clear_state();
      put_desc(32'h100, e[191:160], e[159:128], e[127:96], e[95:64], ENDM);
      wr(2, 32'h100); wr(0, 1);
      wait_queue("R4 table run");
      chk("R3 table data", mem[e[63:32] >> 2], e[31:0]);
      chk("R5 one package", pkg_n, 1);
      chk("R11 one half", half_n, 1);
      rd(0, v); chk("R4 idle after end", v, 0);
      rd(6, v); chk("R10 count zero", v, 0);
    end

    clear_state();
    put_desc(32'h100, 32'h0001_0001, 32'h000, 32'h200, 32'd8, ENDM);
    wr(2, 32'h100); wr(0, 1);
    repeat (20) @(negedge clk);
    wr(1, 32'h2);
    repeat (3) @(negedge clk);
    rd(6, c1);
    checks++;
    if (c1 == 0 || c1 >= 8) begin errors++; $display("FAIL R7 mid-run count: actual %h expected 1..7", c1); end
    acc_n = 0;
    repeat (30) @(negedge clk);
    chk("R7 no access while paused", acc_n, 0);
    rd(6, v); chk("R7 count holds", v, c1);
    rd(4, v); chk("R10 live source", v, 8 - c1);
    rd(5, v); chk("R10 live dest", v, 32'h208 - c1);
    rd(2, v); chk("R10 link pointer", v, ENDM);
    rd(3, v); chk("R10 config", v, 32'h0001_0001);
    rd(7, v); chk("R10 parameter", v, 8);
    rd(1, v); chk("R7 pause readback", v, 2);
    wr(1, 0);
    wait_queue("R7 resume");
    chk("R7 data low", mem[128], 32'h0302_0100);
    chk("R7 data high", mem[129], 32'h0706_0504);
    chk("R11 half once byte mode", half_n, 1);

    clear_state();
    put_desc(32'h100, 32'h0401_0425, 32'h060, 32'h340, 32'd8, ENDM);
    wr(2, 32'h100); wr(0, 1);
    repeat (50) @(negedge clk);
    rd(6, v); chk("R9 waits for request", v, 8);
    chk("R9 nothing written", mem[32'h340 >> 2], 0);
    drq[5] = 1'b1;
    wait_queue("R9 paced run");
    drq[5] = 1'b0;
    chk("R9 paced data", mem[32'h344 >> 2], 32'h6362_6160);

    clear_state();
    put_desc(32'h100, 32'h0401_0401, 32'h070, 32'h380, 32'd4, 32'h140);
    put_desc(32'h140, 32'h0401_0401, 32'h074, 32'h384, 32'd4, ENDM);
    wr(2, 32'h100); wr(0, 1);
    wait_queue("R5 chain");
    chk("R5 two packages", pkg_n, 2);
    chk("R4 single end", q_n, 1);
    chk("R4 end without package", q_alone, 0);
    chk("R4 package before end", pkg_alone, 1);
    chk("R5 first data", mem[32'h380 >> 2], 32'h7372_7170);
    chk("R2 second data", mem[32'h384 >> 2], 32'h7776_7574);

    clear_state();
    put_desc(32'h140, 32'h0401_0401, 32'h074, 32'h384, 32'd4, 32'h100);
    wr(2, 32'h100); wr(0, 1);
    repeat (300) @(negedge clk);
    checks++;
    if (pkg_n < 4) begin errors++; $display("FAIL R6 loop packages: actual %0d expected >=4", pkg_n); end
    chk("R6 no end in loop", q_n, 0);
    rd(0, v); chk("R6 still busy", v, 1);
    wr(0, 0);
    rd(0, v); chk("R8 idle after stop", v, 0);
    acc_n = 0; pkg_n = 0;
    repeat (20) @(negedge clk);
    chk("R8 silent after stop", acc_n + pkg_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule